// File: doc/BRIEF.md
# Clock-Synchronous Serial Transmitter with Clear-to-Send

This block is the sending half of a clock-synchronous serial link in which it is the clock master. Software places one byte in a holding buffer. When the link is enabled, the buffer holds data and the far end pulls the active-low clear-to-send input low, the byte moves into a shift register. It then leaves on the serial data line, least significant bit first, one bit per transfer-clock period. The transfer clock is produced inside the block by dividing the system clock. Between frames it rests high.

A frame may begin only while the end-of-frame window is open. The window is open whenever no frame is running, and also during the single system cycle that closes the last high half of a running frame. If software refills the buffer before that closing cycle, the next frame starts with no gap and the clock keeps its period. Once a frame has begun, later changes on clear-to-send, the enable input or the buffer do not affect it.

Three status outputs report the state of the block. A buffer-empty flag shows whether the holding buffer has been consumed. A one-cycle interrupt pulse marks each time the buffer becomes empty. A transmitter-empty flag shows that the line has gone idle.

Top module: `sync_ser_tx`

## Requirements
- R1: A frame begins on the clock edge that ends a cycle in which the window is open, `tx_en`=1, `buf_empty`=0 and `cts_n`=0. From that edge, `sclk`=0, `sdo` carries bit 0 of the byte and `tx_empty`=0.
- R2: A write (`wr_en`=1) makes `buf_empty` 0 from the next edge. A transfer into the shift register makes it 1 from the next edge. A write in the same cycle as a transfer wins: the old byte is sent and the new byte stays pending, with `buf_empty`=0.
- R3: `sdo` changes only on the edge where `sclk` falls, and never while a frame runs with `sclk` high. Each half of the transfer clock lasts `half_div`+1 system cycles. `sclk` and `sdo` rest at 1 while idle.
- R4: Each frame sends 8 bits, least significant first, in 16 clock halves. Bit k is on `sdo` from the start of low half 2k until the next falling edge.
- R5: Within a running frame, `cts_n` going high, `tx_en` going low or a buffer write do not alter `sclk` or `sdo`. A byte written mid-frame stays pending.
- R6: If the start conditions hold in the closing cycle of a frame, the next frame's first low half follows directly after the last high half. `tx_empty` stays 0.
- R7: When a frame ends with no successor, `sclk` and `sdo` are 1 from the next edge, the window opens, and `tx_empty` becomes 1 one cycle later. `tx_empty` is 0 throughout any frame.
- R8: `irq` is 1 for exactly one cycle, namely the cycle in which `buf_empty` has just changed from 0 to 1.
- R9: A write while the buffer is full replaces the pending byte without any error indication. The next frame sends the last byte written.
- R10: While `rst` is 1, and right after it is released, `sclk`=1, `sdo`=1, `buf_empty`=1, `tx_empty`=1 and `irq`=0.
- R11: While idle, no frame starts if `tx_en`=0 or `cts_n`=1, even with a full buffer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| tx_en | input | 1 | Transmit enable |
| cts_n | input | 1 | Clear-to-send from the receiver, active low |
| wr_en | input | 1 | Write strobe for the holding buffer |
| wr_data | input | DATA_W | Byte to place in the holding buffer |
| half_div | input | DIV_W | Transfer-clock half period minus one, in system cycles |
| sclk | output | 1 | Transfer clock, rests high |
| sdo | output | 1 | Serial data, LSB first |
| buf_empty | output | 1 | Holding buffer holds no unsent byte |
| tx_empty | output | 1 | Transmitter idle |
| irq | output | 1 | One-cycle pulse when the buffer becomes empty |

## Verification
Every result is registered. A frame's first falling clock, the change of `buf_empty` and the `irq` pulse therefore appear at the edge right after the cycle that causes them. Within a frame, offset i from the starting edge lies in half i/(`half_div`+1), so the bench predicts `sclk` and `sdo` arithmetically at each offset. `tx_empty` rises one cycle after the offset 16·(`half_div`+1) at which the line returns high. The bench samples on the falling edge of the system clock and walks these offsets one cycle at a time, with no fixed waits, for `half_div` from 0 to 3.

// File: rtl/sct_pkg.sv
package sct_pkg;
  typedef enum logic {
    PH_LOW  = 1'b0,
    PH_HIGH = 1'b1
  } half_e;
endpackage

// File: rtl/sct_divider.sv
module sct_divider #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run,
  input  logic             restart,
  input  logic [DIV_W-1:0] half_div,
  output logic             tick
);
  logic [DIV_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || restart || !run) cnt <= '0;
    else if (cnt == half_div)   cnt <= '0;
    else                        cnt <= cnt + 1'b1;
  end

  assign tick = run && (cnt == half_div);
endmodule

// File: rtl/sct_holdbuf.sv
module sct_holdbuf #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              take,
  output logic [DATA_W-1:0] data,
  output logic              empty,
  output logic              irq
);
  always_ff @(posedge clk) begin
    if (rst) begin
      data  <= '0;
      empty <= 1'b1;
      irq   <= 1'b0;
    end else begin
      if (wr_en) data <= wr_data;
      if (wr_en)     empty <= 1'b0;
      else if (take) empty <= 1'b1;
      irq <= take && !wr_en;
    end
  end
endmodule

// File: rtl/sct_shifter.sv
module sct_shifter
  import sct_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [DATA_W-1:0] load,
  input  logic              tick,
  output logic              active,
  output logic              tend,
  output logic              sclk,
  output logic              sdo,
  output logic              tx_empty
);
  localparam int CNT_W = (DATA_W > 2) ? $clog2(DATA_W) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(DATA_W - 1);

  half_e             phase;
  logic [CNT_W-1:0]  bitn;
  logic [DATA_W-1:0] shreg;
  logic              last_tick;

  assign last_tick = active && tick && (phase == PH_HIGH) && (bitn == LAST);
  assign tend      = !active || last_tick;

  always_ff @(posedge clk) begin
    if (rst) begin
      active   <= 1'b0;
      phase    <= PH_LOW;
      bitn     <= '0;
      shreg    <= '0;
      sclk     <= 1'b1;
      sdo      <= 1'b1;
      tx_empty <= 1'b1;
    end else if (start) begin
      active   <= 1'b1;
      phase    <= PH_LOW;
      bitn     <= '0;
      shreg    <= load >> 1;
      sclk     <= 1'b0;
      sdo      <= load[0];
      tx_empty <= 1'b0;
    end else begin
      if (!active) tx_empty <= 1'b1;
      if (active && tick) begin
        if (phase == PH_LOW) begin
          sclk  <= 1'b1;
          phase <= PH_HIGH;
        end else if (bitn == LAST) begin
          active <= 1'b0;
          sdo    <= 1'b1;
        end else begin
          sclk  <= 1'b0;
          sdo   <= shreg[0];
          shreg <= shreg >> 1;
          bitn  <= bitn + 1'b1;
          phase <= PH_LOW;
        end
      end
    end
  end
endmodule

// File: rtl/sync_ser_tx.sv
module sync_ser_tx #(
  parameter int DATA_W = 8,
  parameter int DIV_W  = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tx_en,
  input  logic              cts_n,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [DIV_W-1:0]  half_div,
  output logic              sclk,
  output logic              sdo,
  output logic              buf_empty,
  output logic              tx_empty,
  output logic              irq
);
  logic              frame_active;
  logic              frame_end_win;
  logic              tick;
  logic              start;
  logic [DATA_W-1:0] pend_data;

  assign start = frame_end_win && tx_en && !buf_empty && !cts_n;

  sct_divider #(.DIV_W(DIV_W)) div_i (
    .clk(clk), .rst(rst), .run(frame_active), .restart(start),
    .half_div(half_div), .tick(tick)
  );

  sct_holdbuf #(.DATA_W(DATA_W)) buf_i (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data),
    .take(start), .data(pend_data), .empty(buf_empty), .irq(irq)
  );

  sct_shifter #(.DATA_W(DATA_W)) shf_i (
    .clk(clk), .rst(rst), .start(start), .load(pend_data), .tick(tick),
    .active(frame_active), .tend(frame_end_win), .sclk(sclk), .sdo(sdo),
    .tx_empty(tx_empty)
  );
endmodule

// File: rtl/sct_tx_checker.sv
module sct_tx_checker (
  input logic clk,
  input logic rst,
  input logic cts_n,
  input logic wr_en,
  input logic sclk,
  input logic sdo,
  input logic buf_empty,
  input logic tx_empty,
  input logic irq,
  input logic active,
  input logic tend
);
  a_r2_write_fills: assert property (@(posedge clk) disable iff (rst)
    wr_en |=> !buf_empty);

  a_r8_irq_on_rise: assert property (@(posedge clk) disable iff (rst)
    $rose(buf_empty) |-> irq);

  a_r8_irq_only_rise: assert property (@(posedge clk) disable iff (rst)
    irq |-> $rose(buf_empty));

  a_r11_cts_holds_idle: assert property (@(posedge clk) disable iff (rst)
    (tx_empty && cts_n) |=> tx_empty);

  a_r3_idle_lines_high: assert property (@(posedge clk) disable iff (rst)
    tx_empty |-> (sclk && sdo));

  a_r5_no_abort: assert property (@(posedge clk) disable iff (rst)
    (active && !tend) |=> active);

  a_r3_sdo_on_fall: assert property (@(posedge clk) disable iff (rst)
    (active && $past(active) && !$fell(sclk)) |-> $stable(sdo));

  a_r7_empty_after_window: assert property (@(posedge clk) disable iff (rst)
    (!active && $past(!active)) |-> tx_empty);
endmodule

bind sync_ser_tx sct_tx_checker chk_i (
  .clk(clk), .rst(rst), .cts_n(cts_n), .wr_en(wr_en), .sclk(sclk),
  .sdo(sdo), .buf_empty(buf_empty), .tx_empty(tx_empty), .irq(irq),
  .active(frame_active), .tend(frame_end_win)
);

// File: tb/sync_ser_tx_tb.sv
module sync_ser_tx_tb_top;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       tx_en = 1'b0;
  logic       cts_n = 1'b1;
  logic       wr_en = 1'b0;
  logic [7:0] wr_data = '0;
  logic [7:0] half_div = '0;
  logic       sclk, sdo, buf_empty, tx_empty, irq;

  int  n_tests = 0;
  int  n_fail  = 0;
  bit  done    = 1'b0;

  always #4 clk = ~clk;

  sync_ser_tx #(.DATA_W(8), .DIV_W(8)) dut_i (
    .clk(clk), .rst(rst), .tx_en(tx_en), .cts_n(cts_n), .wr_en(wr_en),
    .wr_data(wr_data), .half_div(half_div), .sclk(sclk), .sdo(sdo),
    .buf_empty(buf_empty), .tx_empty(tx_empty), .irq(irq)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  // Called at offset 0 (first sample after the starting edge); returns at offset 16*(d+1).
  task automatic watch_frame(input logic [7:0] b, input int d, input bit exp_irq,
                             input bit pert, input bit do_wr, input logic [7:0] nb);
    int hp = d + 1;
    for (int i = 0; i < 16 * hp; i++) begin
      int h = i / hp;
      int es = h % 2;
      int ed = int'(b[h / 2]);
      chk(sclk == es[0], (i == 0) ? "R1 sclk" : "R3 sclk", int'(sclk), es);
      chk(sdo == ed[0], (i == 0) ? "R1 sdo" : "R4 sdo", int'(sdo), ed);
      chk(tx_empty == 1'b0, "R7 tx_empty in frame", int'(tx_empty), 0);
      chk(irq == ((i == 0) ? exp_irq : 1'b0), "R8 irq", int'(irq),
          (i == 0) ? int'(exp_irq) : 0);
      if (i == 8 * hp) begin
        if (pert) begin cts_n = 1'b1; tx_en = 1'b0; end
        if (do_wr) begin wr_en = 1'b1; wr_data = nb; end
      end
      if (i == 8 * hp + 1) wr_en = 1'b0;
      step();
    end
  endtask

  task automatic idle_end();
    chk(sclk == 1'b1, "R7 sclk high at end", int'(sclk), 1);
    chk(sdo == 1'b1, "R7 sdo high at end", int'(sdo), 1);
    chk(tx_empty == 1'b0, "R7 tx_empty not yet", int'(tx_empty), 0);
    step();
    chk(tx_empty == 1'b1, "R7 tx_empty rises", int'(tx_empty), 1);
  endtask

  // Write b and start at once; returns at offset 0.
  task automatic kick(input logic [7:0] b);
    wr_en = 1'b1; wr_data = b; tx_en = 1'b1; cts_n = 1'b0;
    step();
    wr_en = 1'b0;
    chk(buf_empty == 1'b0, "R2 write fills", int'(buf_empty), 0);
    step();
    chk(buf_empty == 1'b1, "R2 transfer empties", int'(buf_empty), 1);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) step();
    chk(sclk == 1'b1 && sdo == 1'b1 && buf_empty == 1'b1 && tx_empty == 1'b1 && irq == 1'b0,
        "R10 in reset", {sclk, sdo, buf_empty, tx_empty, irq}, 5'b11110);
    rst = 1'b0;
    step();
    chk(sclk == 1'b1 && sdo == 1'b1 && buf_empty == 1'b1 && tx_empty == 1'b1 && irq == 1'b0,
        "R10 after reset", {sclk, sdo, buf_empty, tx_empty, irq}, 5'b11110);

    // R11: idle holds with enable low or clear-to-send high
    half_div = 8'd1;
    cts_n = 1'b0; tx_en = 1'b0; wr_en = 1'b1; wr_data = 8'h3C;
    step();
    wr_en = 1'b0;
    for (int k = 0; k < 10; k++) begin
      chk(tx_empty == 1'b1 && sclk == 1'b1, "R11 tx_en low", int'(tx_empty), 1);
      step();
    end
    tx_en = 1'b1; cts_n = 1'b1;
    for (int k = 0; k < 10; k++) begin
      chk(tx_empty == 1'b1 && buf_empty == 1'b0, "R11 cts high", int'(tx_empty), 1);
      step();
    end
    cts_n = 1'b0;
    step();
    chk(irq == 1'b1, "R8 pulse on start", int'(irq), 1);
    watch_frame(8'h3C, 1, 1'b1, 1'b0, 1'b0, 8'h00);
    idle_end();

    for (int d = 0; d < 4; d++) begin
      half_div = 8'(d);
      step();
      // single frames, several patterns
      for (int j = 0; j < 6; j++) begin
        logic [7:0] b;
        b = (j == 0) ? 8'h01 : (j == 1) ? 8'h80 : 8'((j * 53 + d * 17) ^ 8'hA5);
        kick(b);
        watch_frame(b, d, 1'b1, 1'b0, 1'b0, 8'h00);
        idle_end();
      end
      // R6 back-to-back
      kick(8'hC3);
      watch_frame(8'hC3, d, 1'b1, 1'b0, 1'b1, 8'h96);
      chk(sclk == 1'b0 && tx_empty == 1'b0, "R6 no gap", {sclk, tx_empty}, 0);
      watch_frame(8'h96, d, 1'b1, 1'b0, 1'b0, 8'h00);
      idle_end();
      // R5 mid-frame disturbance, byte stays pending
      kick(8'h5E);
      watch_frame(8'h5E, d, 1'b1, 1'b1, 1'b1, 8'hE7);
      idle_end();
      tx_en = 1'b1;
      for (int k = 0; k < 5; k++) begin
        chk(tx_empty == 1'b1 && sclk == 1'b1, "R5 held by cts", int'(tx_empty), 1);
        chk(buf_empty == 1'b0, "R5 write kept", int'(buf_empty), 0);
        step();
      end
      cts_n = 1'b0;
      step();
      watch_frame(8'hE7, d, 1'b1, 1'b0, 1'b0, 8'h00);
      idle_end();
      // R2 write in the same cycle as the transfer
      tx_en = 1'b1; cts_n = 1'b1; wr_en = 1'b1; wr_data = 8'h4B;
      step();
      cts_n = 1'b0; wr_en = 1'b1; wr_data = 8'hD2;
      step();
      wr_en = 1'b0;
      chk(buf_empty == 1'b0, "R2 write wins", int'(buf_empty), 0);
      watch_frame(8'h4B, d, 1'b0, 1'b0, 1'b0, 8'h00);
      watch_frame(8'hD2, d, 1'b1, 1'b0, 1'b0, 8'h00);
      idle_end();
      // R9 overwrite while full
      tx_en = 1'b0; wr_en = 1'b1; wr_data = 8'h11;
      step();
      wr_data = 8'hEE;
      step();
      wr_en = 1'b0;
      chk(buf_empty == 1'b0 && tx_empty == 1'b1, "R9 pending", int'(buf_empty), 0);
      tx_en = 1'b1;
      step();
      watch_frame(8'hEE, d, 1'b1, 1'b0, 1'b0, 8'h00);
      idle_end();
    end

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule